// File: doc/BRIEF.md
# Programmable Baud Clock Divider

This block generates the 16x oversampling clock for a 16550-style serial port. It divides a reference clock by a 16-bit divisor, so the rate it produces is sixteen times the wanted baud rate. For example, with a 1.8432 MHz reference a divisor of 12 gives 9600 baud and a divisor of 2304 gives 50 baud. The divisor is held in two byte-wide latches. Software writes them one at a time through a small write port. Any write reloads the down-counter at once, so a new rate takes effect without waiting out the rest of an old, possibly very long, period.

There are two reference clocks, and a select input chooses between them. Each reference is modelled as a one-cycle enable pulse on the single system clock, which keeps the whole design synchronous. The block has two outputs. The first is a waveform output that shows the divided clock shape. The second is a one-cycle tick that the serial engine uses as its clock enable at each period boundary. Divisor values 0, 1 and 2 are not illegal: each produces a defined special waveform.

Top module: `baud_divider`

## Requirements
- R1: After reset both divisor bytes are zero, `baud_out` is 0 and `baud_tick` is 0, and the block divides by 3 until software loads a divisor.
- R2: A write with `wr_sel` = 0 loads `wr_data` into bits 7:0 of the divisor, and a write with `wr_sel` = 1 loads bits 15:8; the other byte keeps its value.
- R3: A write to either byte reloads the counter in the same clock edge with the new divisor D (3 if D is 0); the first tick then comes on the D-th selected reference pulse after the write, and `baud_tick` is 0 in the cycle after a write.
- R4: For a divisor D of 3 or more, `baud_tick` fires once every D selected reference pulses, and `baud_out` is 0 for the first two reference periods after each boundary and 1 for the remaining D-2.
- R5: For a divisor of 2, `baud_out` alternates on each selected reference pulse (50% duty), and `baud_tick` fires on every second pulse.
- R6: A divisor of 0 behaves exactly like a divisor of 3: `baud_out` is low for 2 pulses and high for 1, and a tick comes every 3 pulses.
- R7: For a divisor of 1, `baud_out` in each cycle is the inverse of the selected reference enable of the cycle before, and `baud_tick` follows every selected reference pulse.
- R8: With `src_sel` = 0 only `ref_en_a` advances the counter, and with `src_sel` = 1 only `ref_en_b` does; pulses on the unselected input have no effect on either output.
- R9: `baud_tick` is high for exactly the one cycle after the selected reference pulse that ends a period; a tick only follows a selected reference pulse.
- R10: In cycles with no selected reference pulse and no write, the count is held and, for divisors other than 1, `baud_out` and `baud_tick` stay at 0 tick / unchanged waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_en_a | input | 1 | Enable pulse of reference clock A |
| ref_en_b | input | 1 | Enable pulse of reference clock B |
| src_sel | input | 1 | Reference select: 0 = A, 1 = B |
| wr_en | input | 1 | Divisor byte write strobe |
| wr_sel | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| wr_data | input | 8 | Divisor byte to write |
| baud_out | output | 1 | Divided clock waveform |
| baud_tick | output | 1 | One-cycle clock enable at each period boundary |

## Verification
Some properties are checked by assertions on every cycle:
- the count stays between 1 and the effective divisor;
- the count holds when there is neither a selected reference pulse nor a write;
- a write is never followed by a tick;
- every tick follows a selected reference pulse;
- a write to the low byte captures the data.

Other behaviour can only be shown by the bench's scenarios, which compare every cycle against an independent reference model. This covers:
- the exact waveform shapes for divisors 0, 1, 2 and 3 or more;
- the period length measured from a reload in the middle of a period;
- the way the two bytes combine into one divisor;
- the fact that pulses on the unselected reference are ignored.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

    // Waveform variant chosen by the effective divisor value
    typedef enum logic [1:0] {
        WAVE_DIV3  = 2'd0,  // divisor register holds zero
        WAVE_INV   = 2'd1,  // divisor of one: inverted reference
        WAVE_HALF  = 2'd2,  // divisor of two: square wave
        WAVE_PULSE = 2'd3   // divisor of three or more
    } wave_mode_e;

    // Reset value of the down-counter: effective divisor for a zero register
    localparam int unsigned ZERO_DIV_EFF = 3;

    // Number of reference periods the output spends low per period
    localparam int unsigned LOW_PERIODS = 2;

endpackage

// File: rtl/div_latch.sv
module div_latch #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2,
    localparam int SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int DIV_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_next,
    output logic              div_load
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } latch_st_t;

    latch_st_t st_d, st_q;
    logic [DIV_W-1:0] merged;
    logic             sel_ok;

    assign sel_ok = ({1'b0, wr_sel} < (SEL_W + 1)'(NBYTES));

    // one byte lane per divisor byte
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign merged[b*BYTE_W +: BYTE_W] =
            (wr_en && sel_ok && (wr_sel == SEL_W'(b))) ? wr_data
                                                       : st_q.div[b*BYTE_W +: BYTE_W];
    end

    always_comb begin
        st_d     = st_q;
        st_d.div = merged;
        div_load = wr_en && sel_ok;
        div_next = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    lo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0) |=> (st_q.div[BYTE_W-1:0] == $past(wr_data)));

    // R2
    keep_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.div));

endmodule

// File: rtl/ref_select.sv
module ref_select #(
    parameter int NSRC = 2,
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]  ref_en,
    input  logic [SRC_W-1:0] src_sel,
    output logic             ref_tick
);

    logic [NSRC-1:0] hit;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign hit[s] = ref_en[s] && (src_sel == SRC_W'(s));
    end

    always_comb begin
        ref_tick = |hit;
    end

    // R8
    always_comb begin
        one_src_chk: assert ($onehot0(hit));
    end

endmodule

// File: rtl/baud_counter.sv
module baud_counter
    import baud_div_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             div_load,
    input  logic [DIV_W-1:0] div_next,
    output logic             baud_out,
    output logic             baud_tick
);

    localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);
    localparam logic [DIV_W-1:0] TWO      = DIV_W'(2);
    localparam logic [DIV_W-1:0] DIV_ZERO = DIV_W'(ZERO_DIV_EFF);
    localparam logic [DIV_W-1:0] LOW_N    = DIV_W'(LOW_PERIODS);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             out;
        logic             tick;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [DIV_W-1:0] div_eff;
    wave_mode_e       mode;

    // effective divisor and waveform variant
    always_comb begin
        div_eff = (div_next == '0) ? DIV_ZERO : div_next;
        if (div_next == '0) begin
            mode = WAVE_DIV3;
        end else if (div_next == ONE) begin
            mode = WAVE_INV;
        end else if (div_next == TWO) begin
            mode = WAVE_HALF;
        end else begin
            mode = WAVE_PULSE;
        end
    end

    // next state
    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (div_load) begin
            st_d.cnt = div_eff;
        end else if (ref_tick) begin
            st_d.tick = (st_q.cnt == ONE);
            st_d.cnt  = (st_q.cnt <= ONE) ? div_eff : st_q.cnt - ONE;
        end
        unique case (mode)
            WAVE_INV:  st_d.out = ~ref_tick;
            WAVE_HALF: st_d.out = (st_d.cnt == ONE);
            default:   st_d.out = (st_d.cnt <= div_eff - LOW_N);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= DIV_ZERO;
            st_q.out  <= 1'b0;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign baud_out  = st_q.out;
    assign baud_tick = st_q.tick;

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !div_load |-> (st_q.cnt != '0 && st_q.cnt <= div_eff));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tick && !div_load) |=> $stable(st_q.cnt));

    // R3
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_load |=> !baud_tick);

    // R9
    tick_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> ($past(ref_tick) && !$past(div_load)));

endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 2,
    localparam int SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int DIV_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en_a,
    input  logic              ref_en_b,
    input  logic              src_sel,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              baud_out,
    output logic              baud_tick
);

    logic [DIV_W-1:0] div_next;
    logic             div_load;
    logic             ref_tick;

    div_latch #(
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES)
    ) i_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .div_next (div_next),
        .div_load (div_load)
    );

    ref_select #(
        .NSRC (2)
    ) i_refsel (
        .ref_en   ({ref_en_b, ref_en_a}),
        .src_sel  (src_sel),
        .ref_tick (ref_tick)
    );

    baud_counter #(
        .DIV_W (DIV_W)
    ) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .div_load  (div_load),
        .div_next  (div_next),
        .baud_out  (baud_out),
        .baud_tick (baud_tick)
    );

endmodule

// File: tb/test_baud_divider.sv
`timescale 1ns/1ps
module test_baud_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_en_a = 1'b0, ref_en_b = 1'b0, src_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] wr_sel = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       baud_out, baud_tick;

    int    n_cmp = 0, n_bad = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // reference model state
    int m_lo, m_hi, m_cnt;
    bit m_out, m_tick;

    always #2 clk = ~clk;

    baud_divider i_baud_divider (
        .clk(clk), .rst_n(rst_n), .ref_en_a(ref_en_a), .ref_en_b(ref_en_b),
        .src_sel(src_sel), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .baud_out(baud_out), .baud_tick(baud_tick)
    );

    function automatic int eff_div(int d);
        return (d == 0) ? 3 : d;
    endfunction

    function automatic bit wave(int d, int cnt, bit rf);
        if (d == 1) return !rf;
        if (d == 2) return cnt == 1;
        return cnt <= eff_div(d) - 2;
    endfunction

    task automatic compare();
        n_cmp++;
        if (baud_out !== m_out || baud_tick !== m_tick) begin
            n_bad++;
            $display("FAIL %s: out/tick got %b/%b expected %b/%b (divisor %0d)",
                     tag, baud_out, baud_tick, m_out, m_tick, m_hi * 256 + m_lo);
        end
    endtask

    // compare the state predicted last cycle, then drive and predict
    task automatic step(bit a, bit b, bit s, bit w, bit ws, int dat);
        int d;
        bit rf;
        @(negedge clk);
        compare();
        ref_en_a = a; ref_en_b = b; src_sel = s;
        wr_en = w; wr_sel = ws; wr_data = 8'(dat);
        rf = s ? b : a;
        m_tick = 1'b0;
        if (w) begin
            if (ws) m_hi = dat & 255; else m_lo = dat & 255;
            d = m_hi * 256 + m_lo;
            m_cnt = eff_div(d);
        end else begin
            d = m_hi * 256 + m_lo;
            if (rf) begin
                m_tick = (m_cnt == 1);
                m_cnt = (m_cnt <= 1) ? eff_div(d) : m_cnt - 1;
            end
        end
        m_out = wave(d, m_cnt, rf);
    endtask

    task automatic wr(bit ws, int dat);
        step(1'b0, 1'b0, src_sel, 1'b1, ws, dat);
    endtask

    task automatic run_a(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_lo = 0; m_hi = 0; m_cnt = 3; m_out = 1'b0; m_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values, then default divide by 3
        tag = "R1";
        run_a(9);
        // R6: zero divisor, sparse reference pulses
        tag = "R6";
        for (int i = 0; i < 12; i++) step(i[0], 1'b0, 1'b0, 1'b0, 1'b0, 0);
        // R4: divisor 3 and 5
        tag = "R4";
        wr(1'b0, 3); run_a(10);
        wr(1'b0, 5); run_a(16);
        // R5: divisor 2
        tag = "R5";
        wr(1'b0, 2); run_a(9);
        // R7: divisor 1, irregular reference
        tag = "R7";
        wr(1'b0, 1);
        for (int i = 0; i < 12; i++) step(i % 3 != 0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        // R3: reload mid-period from divisor 12 to 4
        tag = "R3";
        wr(1'b0, 12); run_a(5);
        wr(1'b0, 4); run_a(9);
        // R2: high byte combines with low byte (0x0104 = 260), then back
        tag = "R2";
        wr(1'b1, 1); run_a(265);
        wr(1'b1, 0); run_a(10);
        // R8: unselected source ignored, both directions
        tag = "R8";
        wr(1'b0, 6);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 0);
        // R9: tick width with continuous pulses
        tag = "R9";
        wr(1'b0, 3); run_a(12);
        // R10: idle hold
        tag = "R10";
        run_a(1);
        for (int i = 0; i < 15; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0);
        // R4: constrained random mix
        tag = "R4";
        for (int i = 0; i < 4000; i++) begin
            bit w = ($urandom % 100) < 3;
            bit ws = ($urandom % 8) == 0;
            int dat = ws ? int'($urandom % 2) : int'($urandom % 20);
            step(($urandom % 2) == 1, ($urandom % 2) == 1,
                 (i / 500) % 2 == 1, w, ws, dat);
        end
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule